// File: doc/BRIEF.md
# 32-bit Arithmetic Logic Unit with Full-Width Product

This block is a purely combinational arithmetic logic unit for a datapath that needs a complete 32x32 product without a separate multiply unit. It takes two 32-bit operands and a 4-bit operation code and drives a 64-bit result word. That word is wide enough to carry the whole product, the carry or borrow of an add or subtract, and a zero-extended logical result.

Three arithmetic operations are offered: add, subtract and unsigned multiply. The multiplier is built recursively from vertical-and-crosswise 2x2 cells. Each level splits its operands into halves, forms four half-width products and merges them with shifted additions. Eight logical operations are offered: AND, OR, XOR, their complements, NOT of the first operand, and a pass-through of the first operand. The operation code feeds a single result multiplexer. The block has no clock and no state: the result follows the inputs after the combinational delay.

Top module: `alu64`

## Requirements
- R1: Opcode 0 (add): result[31:0] is (A+B) mod 2^32, result[32] is the carry out of bit 31, and result[63:33] is zero.
- R2: Opcode 1 (subtract): result[31:0] is (A-B) mod 2^32. result[32] is the borrow, 1 exactly when A < B as unsigned numbers. result[63:33] is zero.
- R3: Opcode 2 (multiply): result[63:0] is the full unsigned product A*B.
- R4: Opcodes 3, 4 and 5 give A AND B, A OR B and A XOR B in result[31:0].
- R5: Opcodes 6, 7 and 8 give NOT(A AND B), NOT(A OR B) and NOT(A XOR B) in result[31:0].
- R6: Opcode 9 gives the bitwise complement of A in result[31:0]; operand B has no effect on the result.
- R7: Opcode 10 passes A unchanged to result[31:0]; operand B has no effect on the result.
- R8: Opcodes 11 to 15 drive a result of all zeros.
- R9: For every logical opcode (3 to 10), result[63:32] is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand (A) |
| op_b | input | 32 | Second operand (B) |
| opcode | input | 4 | Operation select, encoding as in the requirements |
| result | output | 64 | Result word |

## Verification
The cases hardest to reach from the ports are those where a carry has to run the full length of a structure. Examples are a product of two all-ones operands, whose carries cross every level of the recursive merge, and an add or subtract that wraps by exactly one. Random operands almost never hit these, so the stimulus applies zero, one and all-ones operands under every opcode before it moves to random values. For NOT and pass-through, the stimulus holds A fixed and changes B to show that B has no effect.

// File: rtl/alu64_pkg.sv
package alu64_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_MUL  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_NAND = 4'd6,
        OP_NOR  = 4'd7,
        OP_XNOR = 4'd8,
        OP_NOTA = 4'd9,
        OP_PASS = 4'd10
    } alu_op_e;
endpackage

// File: rtl/vw_mul.sv
// Recursive vertical-and-crosswise multiplier; W must be a power of two >= 2.
module vw_mul #(
    parameter int W = 32
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    localparam int H = W / 2;

    generate
        if (W == 2) begin : g_leaf
            logic t_lo, t_x1, t_x2, t_hi, c_mid;
            always_comb begin
                t_lo  = a[0] & b[0];          // vertical, low column
                t_x1  = a[1] & b[0];          // crosswise terms
                t_x2  = a[0] & b[1];
                t_hi  = a[1] & b[1];          // vertical, high column
                c_mid = t_x1 & t_x2;          // half adder carry
                p     = {t_hi & c_mid, t_hi ^ c_mid, t_x1 ^ t_x2, t_lo};
            end
        end else begin : g_split
            logic [W-1:0] p_ll, p_lh, p_hl, p_hh;
            vw_mul #(.W(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(p_ll));
            vw_mul #(.W(H)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(p_lh));
            vw_mul #(.W(H)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(p_hl));
            vw_mul #(.W(H)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(p_hh));
            always_comb begin
                p = {p_hh, p_ll}
                  + {{H{1'b0}}, p_lh, {H{1'b0}}}
                  + {{H{1'b0}}, p_hl, {H{1'b0}}};
            end
        end
    endgenerate

    // Product bit 0 depends only on the operand LSBs; a zero operand gives zero.
    always_comb begin
        if (!$isunknown({a, b})) begin
            p_mul_lsb_r3: assert (p[0] == (a[0] & b[0]))
                else $error("product bit 0 wrong");
            p_mul_zero_r3: assert (!((a == '0) || (b == '0)) || (p == '0))
                else $error("zero operand gave nonzero product");
        end
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W:0]   res
);
    always_comb begin
        if (sub) res = {1'b0, a} - {1'b0, b};
        else     res = {1'b0, a} + {1'b0, b};
    end

    // Inverse relations: adding back or taking away must recover A.
    always_comb begin
        if (!$isunknown({a, b, sub})) begin
            if (!sub) begin
                p_add_inverse_r1: assert (res[W-1:0] - b == a)
                    else $error("add result inconsistent");
                p_add_carry_r1: assert (res[W] == (res[W-1:0] < a))
                    else $error("carry flag inconsistent");
            end else begin
                p_sub_inverse_r2: assert (res[W-1:0] + b == a)
                    else $error("subtract result inconsistent");
                p_sub_borrow_r2: assert (res[W] == (res[W-1:0] > a))
                    else $error("borrow flag inconsistent");
            end
        end
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int W = 32
) (
    input  alu64_pkg::alu_op_e op,
    input  logic [W-1:0]       a,
    input  logic [W-1:0]       b,
    output logic [W-1:0]       y
);
    import alu64_pkg::*;

    always_comb begin
        case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NAND: y = ~(a & b);
            OP_NOR:  y = ~(a | b);
            OP_XNOR: y = ~(a ^ b);
            OP_NOTA: y = ~a;
            OP_PASS: y = a;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu64.sv
module alu64 #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]   op_a,
    input  logic [DW-1:0]   op_b,
    input  logic [3:0]      opcode,
    output logic [2*DW-1:0] result
);
    import alu64_pkg::*;

    localparam int RW = 2 * DW;

    alu_op_e       op;
    logic [DW:0]   as_res;
    logic [RW-1:0] mul_res;
    logic [DW-1:0] log_res;

    assign op = alu_op_e'(opcode);

    alu_addsub #(.W(DW)) u_addsub (
        .a(op_a), .b(op_b), .sub(op == OP_SUB), .res(as_res)
    );

    vw_mul #(.W(DW)) u_mul (
        .a(op_a), .b(op_b), .p(mul_res)
    );

    alu_logic #(.W(DW)) u_logic (
        .op(op), .a(op_a), .b(op_b), .y(log_res)
    );

    always_comb begin
        case (op)
            OP_ADD, OP_SUB: result = {{(RW-DW-1){1'b0}}, as_res};
            OP_MUL:         result = mul_res;
            OP_AND, OP_OR, OP_XOR, OP_NAND, OP_NOR, OP_XNOR, OP_NOTA, OP_PASS:
                            result = {{(RW-DW){1'b0}}, log_res};
            default:        result = '0;
        endcase
    end

    always_comb begin
        if (!$isunknown({op_a, op_b, opcode})) begin
            p_logic_upper_zero_r9: assert (!(opcode >= 4'd3 && opcode <= 4'd10)
                                           || (result[RW-1:DW] == '0))
                else $error("logical result has nonzero upper half");
            p_unused_zero_r8: assert ((opcode <= 4'd10) || (result == '0))
                else $error("unused opcode gave nonzero result");
            p_arith_upper_zero_r1: assert ((opcode > 4'd1) || (result[RW-1:DW+1] == '0))
                else $error("add/sub upper bits nonzero");
        end
    end
endmodule

// File: tb/alu64_test.sv
module alu64_test;
    logic        clk = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [3:0]  opcode = '0;
    logic [63:0] result;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic [63:0] exp;
        logic [3:0]  op;
        string       req;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    alu64 uut (.op_a(op_a), .op_b(op_b), .opcode(opcode), .result(result));

    function automatic logic [63:0] ref_model(input logic [3:0] op,
                                              input logic [31:0] a,
                                              input logic [31:0] b);
        logic [32:0] s;
        case (op)
            4'd0: begin s = {1'b0, a} + {1'b0, b}; return {31'b0, s}; end
            4'd1: return {31'b0, (a < b), a - b};
            4'd2: return {32'b0, a} * {32'b0, b};
            4'd3: return {32'b0, a & b};
            4'd4: return {32'b0, a | b};
            4'd5: return {32'b0, a ^ b};
            4'd6: return {32'b0, ~(a & b)};
            4'd7: return {32'b0, ~(a | b)};
            4'd8: return {32'b0, ~(a ^ b)};
            4'd9: return {32'b0, ~a};
            4'd10: return {32'b0, a};
            default: return 64'b0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3, 4'd4, 4'd5: return "R4";
            4'd6, 4'd7, 4'd8: return "R5";
            4'd9: return "R6";
            4'd10: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        item_t it;
        @(negedge clk);
        opcode = op;
        op_a = a;
        op_b = b;
        it.exp = ref_model(op, a, b);
        it.op = op;
        it.req = req_of(op);
        sb_q.push_back(it);
    endtask

    // Monitor: result is compared half a period after the inputs change.
    always @(posedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (result !== it.exp) begin
                failures++;
                $display("FAIL %s op=%0d got=%h exp=%h", it.req, it.op, result, it.exp);
            end
            if (it.op >= 4'd3 && it.op <= 4'd10) begin
                checks++;
                if (result[63:32] !== 32'b0) begin
                    failures++;
                    $display("FAIL R9 op=%0d got=%h exp=%h", it.op, result[63:32], 32'h0);
                end
            end
        end
    end

    initial begin
        logic [31:0] corner [4];
        corner[0] = 32'h0;
        corner[1] = 32'h1;
        corner[2] = 32'hFFFF_FFFF;
        corner[3] = 32'h8000_0000;

        // Idle state: all-zero inputs select add of zeros.
        drive(4'd0, 32'h0, 32'h0);

        // Corner operands under every opcode, used and unused (R1..R9).
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++)
                    drive(op[3:0], corner[i], corner[j]);

        // Carry/borrow edges.
        drive(4'd0, 32'hFFFF_FFFF, 32'h1);            // R1 wrap to zero, carry 1
        drive(4'd1, 32'h5, 32'h6);                    // R2 borrow by one
        drive(4'd1, 32'h6, 32'h6);                    // R2 equal, no borrow
        drive(4'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);    // R3 max product

        // B must not matter for NOT and pass-through (R6, R7).
        for (int k = 0; k < 8; k++) begin
            logic [31:0] fa;
            fa = $urandom();
            drive(4'd9, fa, $urandom());
            drive(4'd9, fa, ~fa);
            drive(4'd10, fa, $urandom());
            drive(4'd10, fa, 32'h0);
        end

        // Random operands for every opcode.
        for (int op = 0; op < 16; op++)
            for (int n = 0; n < 30; n++)
                drive(op[3:0], $urandom(), $urandom());

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(10 * 100000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule